// File: doc/BRIEF.md
# Serial-Programmed Dual-Channel Gain Controller

This block takes 14-bit control words from a three-wire serial link made of a serial clock, a data line and a latch strobe. It assembles each word in a shift register. A rising edge on the latch strobe then copies the word into the control register of one of two channels, and bit 7 of the word picks which channel. The three serial lines are synchronised into the system clock domain and edge-detected there, so the whole block runs on a single clock.

Each channel register is decoded continuously into the digital controls an analog gain stage would use. These are a signed gain in dB, a mute flag, three input-enable lines and two 2-bit output drive modes. The gain code maps onto a 2 dB ladder. Code zero means mute, and the ladder clamps at the top of its range.

Top module: `dual_gain_ctl`

## Requirements
- R1: After reset both channels read mute=1, gain_db=0, in_en=000, mode_a=00 and mode_b=00.
- R2: Each synchronised rising edge of ser_clk shifts ser_dat into the word register with the most significant bit first, so D13 arrives first and D0 arrives last. Shifting alone never changes any output.
- R3: A word is stored only in the channel that its bit D7 selects: 0 selects channel 0 and 1 selects channel 1. The other channel keeps its outputs unchanged.
- R4: A gain code (D13..D8) in the range 1 to 48 gives gain_db = 2*code - 50 as a 7-bit two's-complement value, with mute=0.
- R5: Gain code 0 gives mute=1 and gain_db=0.
- R6: Gain codes 49 through 63 all give gain_db=+48 with mute=0.
- R7: in_en[0], in_en[1] and in_en[2] equal D4, D5 and D6 of the stored word. Every combination is allowed.
- R8: mode_a equals D3..D2 and mode_b equals D1..D0. The codes are 00 high impedance, 01 driven, 10 pulled to ground and 11 held at bias.
- R9: Exactly one transfer happens for each rising edge of ser_lat. If the strobe stays high while a new word is shifted in, or when it falls, nothing updates until its next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous to clk |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_lat | input | 1 | Latch strobe; its rising edge commits the word |
| gain_db | output | 2x7 | Signed gain in dB per channel |
| mute | output | 2 | Mute flag per channel |
| in_en | output | 2x3 | Input enables per channel |
| mode_a | output | 2x2 | Drive mode of output group A per channel |
| mode_b | output | 2x2 | Drive mode of output group B per channel |

## Verification
The hardest case to reach from the ports is a strobe that stays high while a complete new word is shifted in. If the latch were level-sensitive or retriggered, the channel would follow the shifting bits, and no single clean transfer would show the fault. The stimulus therefore raises the strobe and shifts a whole word with both channel addresses while it is held. It checks that nothing moves before the strobe falls, and that the next rising edge commits only the last word. Random words mixed with directed codes 0, 1, 25, 48, 49 and 63 cover the mute code, both ends of the ladder and the clamp.

// File: rtl/dual_gain_ctl.sv
module dual_gain_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_clk,
  input  logic            ser_dat,
  input  logic            ser_lat,
  output logic [1:0][6:0] gain_db,
  output logic [1:0]      mute,
  output logic [1:0][2:0] in_en,
  output logic [1:0][1:0] mode_a,
  output logic [1:0][1:0] mode_b
);
  localparam int WORD_W = 14;
  localparam int SEL_BIT = 7;
  localparam int TOP_CODE = 49;

  logic [SYNC_STAGES:0] sck_q, lat_q, dat_q;
  logic [WORD_W-1:0]    shreg;
  logic [1:0][WORD_W-1:0] creg;
  logic sck_rise, lat_rise, dat_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      lat_q <= '0;
      dat_q <= '0;
    end else begin
      sck_q <= {sck_q[SYNC_STAGES-1:0], ser_clk};
      lat_q <= {lat_q[SYNC_STAGES-1:0], ser_lat};
      dat_q <= {dat_q[SYNC_STAGES-1:0], ser_dat};
    end

  assign sck_rise = sck_q[SYNC_STAGES-1] & ~sck_q[SYNC_STAGES];
  assign lat_rise = lat_q[SYNC_STAGES-1] & ~lat_q[SYNC_STAGES];
  assign dat_s    = dat_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) shreg <= '0;
    else if (sck_rise) shreg <= {shreg[WORD_W-2:0], dat_s};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) creg <= '0;
    else if (lat_rise) creg[shreg[SEL_BIT]] <= shreg;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [5:0]        code;
    logic signed [7:0] lin;
    assign code = creg[c][13:8];
    assign lin  = $signed({1'b0, code, 1'b0}) - 8'sd50;
    assign mute[c]    = (code == 6'd0);
    assign gain_db[c] = mute[c] ? 7'd0 :
                        (code >= 6'(TOP_CODE)) ? 7'd48 : lin[6:0];
    assign in_en[c]  = creg[c][6:4];
    assign mode_a[c] = creg[c][3:2];
    assign mode_b[c] = creg[c][1:0];
  end
endmodule

module dual_gain_ctl_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            lat_rise,
  input logic [13:0]     shreg,
  input logic [1:0][6:0] gain_db,
  input logic [1:0]      mute,
  input logic [1:0][2:0] in_en,
  input logic [1:0][1:0] mode_a,
  input logic [1:0][1:0] mode_b
);
  logic [1:0][13:0] vis;
  for (genvar c = 0; c < 2; c++) begin : g_v
    assign vis[c] = {gain_db[c], mute[c], in_en[c], mode_a[c], mode_b[c]};
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vis) |-> $past(lat_rise));

  p_one_chan_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(vis[0]) == 1'b0 && $stable(vis[1]) == 1'b0));

  p_sel0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && !shreg[7]) |=> $stable(vis[1]));

  p_sel1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && shreg[7]) |=> $stable(vis[0]));

  for (genvar c = 0; c < 2; c++) begin : g_a
    p_mute_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mute[c] |-> gain_db[c] == 7'd0);
    p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !mute[c] |-> ($signed(gain_db[c]) >= -7'sd48 &&
                    $signed(gain_db[c]) <= 7'sd48 && !gain_db[c][0]));
  end
endmodule

bind dual_gain_ctl dual_gain_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lat_rise(lat_rise), .shreg(shreg),
  .gain_db(gain_db), .mute(mute), .in_en(in_en),
  .mode_a(mode_a), .mode_b(mode_b)
);

// File: tb/dual_gain_ctl_bench.sv
module dual_gain_ctl_bench;
  logic clk = 0, rst_n = 0, ser_clk = 0, ser_dat = 0, ser_lat = 0;
  logic [1:0][6:0] gain_db;
  logic [1:0]      mute;
  logic [1:0][2:0] in_en;
  logic [1:0][1:0] mode_a, mode_b;
  int checks = 0, fails = 0;
  logic [1:0][13:0] exp_w;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_gain_ctl u_dual_gain_ctl (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_lat(ser_lat), .gain_db(gain_db), .mute(mute), .in_en(in_en),
    .mode_a(mode_a), .mode_b(mode_b));

  function automatic int exp_gain(logic [5:0] code);
    if (code == 0) return 0;
    if (code >= 49) return 48;
    return 2 * int'(code) - 50;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int c = 0; c < 2; c++) begin
      logic [5:0] code = exp_w[c][13:8];
      chk({tag, " R4/R6 gain"}, int'($signed(gain_db[c])), exp_gain(code));
      chk({tag, " R5 mute"}, int'(mute[c]), int'(code == 0));
      chk({tag, " R7 in_en"}, int'(in_en[c]), int'(exp_w[c][6:4]));
      chk({tag, " R8 mode_a"}, int'(mode_a[c]), int'(exp_w[c][3:2]));
      chk({tag, " R8 mode_b"}, int'(mode_b[c]), int'(exp_w[c][1:0]));
    end
  endtask

  task automatic shift_word(logic [13:0] w);
    for (int i = 13; i >= 0; i--) begin
      @(negedge clk) ser_dat = w[i];
      repeat (3) @(negedge clk);
      ser_clk = 1;
      repeat (4) @(negedge clk);
      ser_clk = 0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic pulse_latch(logic [13:0] w);
    @(negedge clk) ser_lat = 1;
    repeat (4) @(negedge clk);
    ser_lat = 0;
    repeat (6) @(negedge clk);
    exp_w[w[7]] = w;
  endtask

  task automatic send(logic [13:0] w, string tag);
    shift_word(w);
    pulse_latch(w);
    check_all(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    exp_w = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_all("R1 reset");

    // R2: shifting without a latch changes nothing
    shift_word({6'd30, 1'b0, 3'b101, 4'b0110});
    check_all("R2 shift only");
    pulse_latch({6'd30, 1'b0, 3'b101, 4'b0110});
    check_all("R2 MSB-first commit");

    // R3: channel 1 word leaves channel 0 intact
    send({6'd1, 1'b1, 3'b011, 4'b1101}, "R3 ch1");
    send({6'd25, 1'b0, 3'b000, 4'b0000}, "R4 zero dB");
    send({6'd48, 1'b1, 3'b111, 4'b1111}, "R4 top");
    send({6'd0, 1'b0, 3'b100, 4'b1001}, "R5 mute");
    send({6'd49, 1'b1, 3'b010, 4'b0100}, "R6 49");
    send({6'd63, 1'b0, 3'b001, 4'b0011}, "R6 63");
    send({6'd55, 1'b1, 3'b110, 4'b1000}, "R6 55");

    // R9: strobe held high across a full new word
    @(negedge clk) ser_lat = 1;
    repeat (6) @(negedge clk);
    shift_word({6'd10, 1'b0, 3'b111, 4'b0101});
    check_all("R9 held high");
    shift_word({6'd12, 1'b1, 3'b001, 4'b1010});
    check_all("R9 held high second");
    ser_lat = 0;
    repeat (6) @(negedge clk);
    check_all("R9 falling edge");
    pulse_latch({6'd12, 1'b1, 3'b001, 4'b1010});
    check_all("R9 next rise");

    for (int n = 0; n < 50; n++) begin
      logic [13:0] w = 14'($urandom);
      send(w, "rand R3/R7/R8");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule